// File: doc/BRIEF.md
# Pulse Decoder with Watchdog Default

This block is the receive end of one isolated logic channel. On the far side of the barrier, an encoder sends a single-cycle pulse each time its input changes. It also resends the current level at a steady refresh interval while the input is static. Here, a set pulse or a clear pulse moves a bistable output level high or low, and the level holds between pulses.

A watchdog counts consecutive cycles with no pulse of either kind. When the count reaches the timeout, the input side is taken to be unpowered or broken. The output is then driven to its safe high level and a dead-link flag is raised. The first pulse after that clears the flag and applies its own level at the same clock edge. A set pulse and a clear pulse in the same cycle is illegal. In that case the level keeps its previous value and a sticky error flag latches.

The timeout must be longer than the encoder's refresh interval, so that a healthy static link never trips the watchdog.

Top module: `pdw_channel_rx`

## Requirements
- R1: The reset `rst` is synchronous and active high. While `rst` is high, and at the first check after it is released, `level_out` is 1, `link_dead` is 0 and `conflict_err` is 0.
- R2: A clock edge that samples `set_pulse`=1 with `reset_pulse`=0 makes `level_out` 1 after that edge.
- R3: A clock edge that samples `reset_pulse`=1 with `set_pulse`=0 makes `level_out` 0 after that edge.
- R4: An edge that samples no pulse leaves `level_out` unchanged, unless that edge completes a timeout under R5.
- R5: After `WDT_CYCLES` consecutive edges that sample no pulse, counted from reset release or from the last pulse, `link_dead` is 1 and `level_out` is 1. Both remain so for as long as no pulse arrives.
- R6: Any edge that samples a pulse (set, clear or both) restarts the idle count and makes `link_dead` 0 after that edge. A pulse that ends a dead period applies its level at that same edge.
- R7: Pulses spaced so that no more than `WDT_CYCLES`-1 idle edges fall between them never raise `link_dead`.
- R8: An edge that samples both pulses keeps `level_out` at its previous value and sets `conflict_err` to 1. `conflict_err` then stays 1 until `rst`.
- R9: With set and clear pulses on alternating cycles, `level_out` follows each pulse, one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse | input | 1 | Single-cycle pulse that drives the level high |
| reset_pulse | input | 1 | Single-cycle pulse that drives the level low |
| level_out | output | 1 | Registered decoded level, high by default |
| link_dead | output | 1 | High while the pulse-absence timeout is expired |
| conflict_err | output | 1 | Sticky flag for set and clear sampled together |

## Verification
The two functions that can meet in one cycle are the timeout and a pulse arrival. A pulse can land exactly on the edge that would have completed the idle count, or on the first edge of a dead period. A conflicting pulse pair can also land on such an edge. The bench provokes these cases by counting idle cycles precisely up to `WDT_CYCLES`-1 and to `WDT_CYCLES`. A cycle-level reference model then judges the result: the pulse must win, the flag must drop, and the pulse's own level (or the held level, for a conflict) must appear.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_SET  = 2'd1,
    PK_CLR  = 2'd2,
    PK_BOTH = 2'd3
  } pulse_kind_t;

  localparam logic SAFE_LEVEL = 1'b1;

endpackage

// File: rtl/pdw_pulse_classify.sv
module pdw_pulse_classify
  import pdw_pkg::*;
(
  input  logic        set_i,
  input  logic        clr_i,
  output pulse_kind_t kind_o,
  output logic        activity_o
);

  always_comb begin
    unique case ({clr_i, set_i})
      2'b01:   kind_o = PK_SET;
      2'b10:   kind_o = PK_CLR;
      2'b11:   kind_o = PK_BOTH;
      default: kind_o = PK_NONE;
    endcase
  end

  assign activity_o = set_i | clr_i;

endmodule

// File: rtl/pdw_watchdog.sv
module pdw_watchdog #(
  parameter int unsigned WDT_CYCLES = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic activity_i,
  output logic expire_o,
  output logic dead_o
);

  localparam int unsigned CW    = $clog2(WDT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WDT_CYCLES - 1);

  logic [CW-1:0] idle_cnt;

  // High on the idle edge that completes the timeout, and on every
  // idle edge while it stays expired.
  assign expire_o = !activity_i && (idle_cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
      dead_o   <= 1'b0;
    end else if (activity_i) begin
      idle_cnt <= '0;
      dead_o   <= 1'b0;
    end else if (idle_cnt == LIMIT) begin
      dead_o   <= 1'b1;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    idle_cnt <= LIMIT);                                          // R5
  AST_ACTIVITY_CLEARS_DEAD: assert property (@(posedge clk) disable iff (rst)
    activity_i |=> !dead_o);                                     // R6
  AST_DEAD_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(dead_o) |-> $past(!activity_i));                       // R5
  AST_DEAD_STAYS: assert property (@(posedge clk) disable iff (rst)
    (dead_o && !activity_i) |=> dead_o);                         // R5

endmodule

// File: rtl/pdw_level_latch.sv
module pdw_level_latch
  import pdw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  pulse_kind_t kind_i,
  input  logic        expire_i,
  output logic        level_o,
  output logic        err_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= SAFE_LEVEL;
      err_o   <= 1'b0;
    end else begin
      unique case (kind_i)
        PK_SET:  level_o <= 1'b1;
        PK_CLR:  level_o <= 1'b0;
        PK_BOTH: err_o   <= 1'b1;
        default: if (expire_i) level_o <= SAFE_LEVEL;
      endcase
    end
  end

  AST_SET_HIGH: assert property (@(posedge clk) disable iff (rst)
    (kind_i == PK_SET) |=> level_o);                             // R2
  AST_CLR_LOW: assert property (@(posedge clk) disable iff (rst)
    (kind_i == PK_CLR) |=> !level_o);                            // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (kind_i == PK_NONE && !expire_i) |=> $stable(level_o));      // R4
  AST_CONFLICT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (kind_i == PK_BOTH) |=> ($stable(level_o) && err_o));        // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);                                            // R8

endmodule

// File: rtl/pdw_channel_rx.sv
module pdw_channel_rx
  import pdw_pkg::*;
#(
  parameter int unsigned WDT_CYCLES = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic set_pulse,
  input  logic reset_pulse,
  output logic level_out,
  output logic link_dead,
  output logic conflict_err
);

  pulse_kind_t kind;
  logic        activity;
  logic        expire;

  pdw_pulse_classify u_classify (
    .set_i      (set_pulse),
    .clr_i      (reset_pulse),
    .kind_o     (kind),
    .activity_o (activity)
  );

  pdw_watchdog #(.WDT_CYCLES(WDT_CYCLES)) u_wdt (
    .clk        (clk),
    .rst        (rst),
    .activity_i (activity),
    .expire_o   (expire),
    .dead_o     (link_dead)
  );

  pdw_level_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .kind_i   (kind),
    .expire_i (expire),
    .level_o  (level_out),
    .err_o    (conflict_err)
  );

  AST_DEAD_IMPLIES_HIGH: assert property (@(posedge clk) disable iff (rst)
    link_dead |-> level_out);                                    // R5
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (level_out && !link_dead && !conflict_err));         // R1

endmodule

// File: tb/pdw_channel_rx_tb_top.sv
module pdw_channel_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDT        = 20;
  localparam int WATCHDOG_LIMIT = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic set_pulse = 1'b0;
  logic reset_pulse = 1'b0;
  logic level_out, link_dead, conflict_err;

  int tests_run = 0;
  int tests_failed = 0;
  int cycles = 0;

  // Reference state
  bit m_level = 1'b1;
  bit m_dead  = 1'b0;
  bit m_err   = 1'b0;
  int m_idle  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdw_channel_rx #(.WDT_CYCLES(WDT)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .set_pulse    (set_pulse),
    .reset_pulse  (reset_pulse),
    .level_out    (level_out),
    .link_dead    (link_dead),
    .conflict_err (conflict_err)
  );

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG_LIMIT) begin
      tests_run = tests_run + 1;
      tests_failed = tests_failed + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < %0d",
               cycles, WATCHDOG_LIMIT);
      finish_run();
    end
  end

  task automatic model_edge(input bit r, input bit s, input bit c);
    if (r) begin
      m_level = 1'b1; m_dead = 1'b0; m_err = 1'b0; m_idle = 0;
    end else if (s || c) begin
      m_idle = 0;
      m_dead = 1'b0;
      if (s && c) m_err = 1'b1;
      else m_level = s;
    end else begin
      m_idle = m_idle + 1;
      if (m_idle >= WDT) begin
        m_idle = WDT;
        m_dead = 1'b1;
        m_level = 1'b1;
      end
    end
  endtask

  // Called at a falling edge: drive, pass one rising edge, compare at next fall.
  task automatic cyc(input bit s, input bit c, input string tag);
    set_pulse = s;
    reset_pulse = c;
    @(posedge clk);
    model_edge(rst, s, c);
    @(negedge clk);
    tests_run = tests_run + 1;
    if (level_out !== m_level || link_dead !== m_dead || conflict_err !== m_err) begin
      tests_failed = tests_failed + 1;
      $display("FAIL %s: actual level=%b dead=%b err=%b expected level=%b dead=%b err=%b",
               tag, level_out, link_dead, conflict_err, m_level, m_dead, m_err);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, tag);
  endtask

  initial begin
    @(negedge clk);
    rst = 1'b1;
    cyc(1'b0, 1'b0, "R1 in reset");
    cyc(1'b1, 1'b1, "R1 pulses ignored in reset");
    rst = 1'b0;
    cyc(1'b0, 1'b0, "R1 after release");

    // Timeout from reset: WDT idle edges in total since release
    idle(WDT - 2, "R4 idle before timeout");
    cyc(1'b0, 1'b0, "R5 timeout edge");
    idle(5, "R5 stays dead");

    // Clear pulse ends the dead period
    cyc(1'b0, 1'b1, "R6 clear ends dead");
    idle(WDT - 1, "R4 hold low");
    cyc(1'b1, 1'b0, "R6 set on last idle slot");
    cyc(1'b0, 1'b1, "R3 clear");
    idle(WDT - 2, "R4 hold low again");

    // Refresh at maximum legal spacing
    for (int k = 0; k < 6; k++) begin
      cyc(1'b0, 1'b1, "R7 refresh low");
      idle(WDT - 1, "R7 gap");
    end
    cyc(1'b1, 1'b0, "R2 set");
    for (int k = 0; k < 4; k++) begin
      cyc(1'b1, 1'b0, "R7 refresh high");
      idle(WDT - 1, "R7 gap high");
    end

    // Rapid alternation
    for (int k = 0; k < 24; k++)
      cyc(k[0] == 1'b0 ? 1'b0 : 1'b1, k[0] == 1'b0 ? 1'b1 : 1'b0, "R9 alternating");
    cyc(1'b0, 1'b1, "R3 clear before timeout");
    idle(WDT, "R5 timeout from low");

    // Pulse on first dead edge: set
    cyc(1'b1, 1'b0, "R6 set ends dead");
    cyc(1'b0, 1'b1, "R3 clear after recovery");

    // Conflict while low: hold low, err sticky
    cyc(1'b1, 1'b1, "R8 conflict holds low");
    idle(3, "R8 err sticky");
    cyc(1'b1, 1'b0, "R8 set after conflict");
    cyc(1'b0, 1'b1, "R8 clear after conflict");

    // Conflict as the pulse that ends a dead period
    idle(WDT, "R5 timeout again");
    cyc(1'b1, 1'b1, "R6 conflict ends dead");
    idle(WDT - 1, "R7 conflict counts as activity");
    cyc(1'b0, 1'b0, "R5 timeout after conflict");

    // Reset clears sticky error
    rst = 1'b1;
    cyc(1'b0, 1'b0, "R1 reset clears err");
    rst = 1'b0;
    cyc(1'b0, 1'b1, "R3 clear after reset");
    cyc(1'b1, 1'b0, "R2 set after reset");

    set_pulse = 1'b0;
    reset_pulse = 1'b0;
    finish_run();
  end

endmodule